// File: doc/BRIEF.md
# Timer Trigger and Clock-Source Selector

This block sits in front of a general-purpose timer counter and decides two things every cycle: which of several candidate trigger signals is the timer's trigger input, and what advances the counter. A stored 3-bit trigger-select code routes one of five candidates (internal trigger 0, the input-1 edge detector, filtered input 1, filtered input 2, or the conditioned external trigger) onto `trig_in`. The select code can only change while the slave mode is 000, so that a live trigger path never sees a false edge from a mux switch.

The counter's clock source has three choices. With external mode 2 enabled, the counter takes one step per rising edge of the conditioned external trigger. With slave mode 111 (external mode 1), it takes one step per rising edge of the selected trigger. Otherwise it runs on the internal clock. Mode 2 wins when both external modes are on. Mode 2 can run alongside the reset, gated and trigger slave modes, but only when the select code is not 111. When the select code is 111 in mode 2, trigger events are suppressed.

A trigger event is a rising edge of `trig_in` while the slave mode is not 000. Each event produces a one-cycle trigger-output pulse for slave timers. A small state machine (states IDLE and ARMED) handles the master/slave sync bit. With the bit clear, the local trigger action comes out in the same cycle as the output pulse. With the bit set, an event moves IDLE to ARMED (or keeps ARMED armed), and the local action is delivered one cycle after the output pulse. With no event pending, the machine returns to IDLE.

Top module: `tmr_trig_clk_sel`

## Requirements
- R1: `trig_in` follows the candidate chosen by the stored select code: 000 internal trigger 0, 100 input-1 edge detector, 101 filtered input 1, 110 filtered input 2, 111 conditioned external trigger. The path is combinational from the stored code.
- R2: Stored select codes 001, 010 and 011 hold `trig_in` low.
- R3: A select write (`sel_wr` high at a clock edge) stores `sel_wdata` only when `slave_mode` is 000. Otherwise the write is ignored and the previous selection stays in effect.
- R4: With `ext2_en` high, `cnt_en` is high for exactly the one cycle after each clock edge at which `etr_cond` is first seen high following a low sample. At all other times it is low.
- R5: With `ext2_en` low and `slave_mode` 111, `cnt_en` pulses in the same way on rising edges of `trig_in`. With select 111, this counts the same edges as R4.
- R6: When `ext2_en` is high and `slave_mode` is 111, the clock is `etr_cond`. Edges on the selected trigger do not advance the counter.
- R7: With `ext2_en` low and `slave_mode` not 111, `cnt_en` is high on every cycle.
- R8: A rising edge of `trig_in` seen while `slave_mode` is not 000 raises `trig_out` for exactly one cycle, after the next clock edge. With `slave_mode` 000 there is no pulse.
- R9: With `ext2_en` high and select 111, no trigger events are produced. With any other select code, trigger events still occur while mode-2 counting runs.
- R10: With `sync_en` low, `trig_act` pulses in the same cycle as `trig_out`. With `sync_en` high, it pulses exactly one cycle later.
- R11: While `rst_n` is low at a clock edge, the select code returns to 000 and `cnt_en`, `trig_out` and `trig_act` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_wr | input | 1 | Write strobe for the trigger-select code |
| sel_wdata | input | 3 | New trigger-select code |
| slave_mode | input | 3 | Slave mode field (000 off, 111 external mode 1) |
| ext2_en | input | 1 | External clock mode 2 enable |
| sync_en | input | 1 | Master/slave sync: delay local trigger action |
| itr0 | input | 1 | Internal trigger 0 |
| ti1_edge | input | 1 | Input-1 edge detector |
| ti1_filt | input | 1 | Filtered input 1 |
| ti2_filt | input | 1 | Filtered input 2 |
| etr_cond | input | 1 | Conditioned external trigger |
| trig_in | output | 1 | Selected trigger signal |
| cnt_en | output | 1 | Counter advance enable |
| trig_out | output | 1 | Trigger output pulse for slave timers |
| trig_act | output | 1 | Trigger action applied to the local counter |

## Verification
The routing check walks every select code against candidate patterns where only one candidate is high, or where all candidates except the chosen one are high. This separates a correct route from a wrong one or from a stuck output. Clock-source checks toggle `etr_cond` and the selected trigger on their own, so the bench can see which of the two drives `cnt_en` under mode 2, under mode 1 and with both modes on. Trigger pulses are compared with the sync bit clear and set, to show the one-cycle offset. They are also compared in slave mode 000 and with select 111 under mode 2, where no pulse may appear. Rejected select writes are made visible through `trig_in`.

// File: rtl/tmr_sel_pkg.sv
package tmr_sel_pkg;
    localparam int SEL_W  = 3;
    localparam int MODE_W = 3;

    localparam logic [SEL_W-1:0] SEL_ITR0  = 3'b000;
    localparam logic [SEL_W-1:0] SEL_TI1ED = 3'b100;
    localparam logic [SEL_W-1:0] SEL_TI1F  = 3'b101;
    localparam logic [SEL_W-1:0] SEL_TI2F  = 3'b110;
    localparam logic [SEL_W-1:0] SEL_ETR   = 3'b111;

    localparam logic [MODE_W-1:0] MODE_OFF  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_EXT1 = 3'b111;

    typedef enum logic [1:0] {
        SRC_INT,
        SRC_EXT1,
        SRC_EXT2
    } clk_src_t;

    typedef enum logic {
        ST_IDLE,
        ST_ARMED
    } sync_state_t;
endpackage

// File: rtl/tsel_trig_mux.sv
module tsel_trig_mux
    import tmr_sel_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             itr0,
    input  logic             ti1_edge,
    input  logic             ti1_filt,
    input  logic             ti2_filt,
    input  logic             etr_cond,
    output logic             trig
);
    always_comb begin
        unique case (sel)
            SEL_ITR0:  trig = itr0;
            SEL_TI1ED: trig = ti1_edge;
            SEL_TI1F:  trig = ti1_filt;
            SEL_TI2F:  trig = ti2_filt;
            SEL_ETR:   trig = etr_cond;
            default:   trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsel_rise_det.sv
module tsel_rise_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= d[i];
        end
        assign rise[i] = d[i] & ~prev_q[i];
    end
endmodule

// File: rtl/tsel_sync_fsm.sv
module tsel_sync_fsm
    import tmr_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic sync_en,
    output logic trig_out,
    output logic trig_act
);
    sync_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = (evt && sync_en) ? ST_ARMED : ST_IDLE;
            ST_ARMED: state_d = (evt && sync_en) ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_out <= 1'b0;
            trig_act <= 1'b0;
        end else begin
            trig_out <= evt;
            trig_act <= (state_q == ST_ARMED) || (evt && !sync_en);
        end
    end

    // R10: delayed action follows the output pulse by one cycle
    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(sync_en)) |=> trig_act);
    // R10: undelayed action coincides with the output pulse
    assert_sync_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && !$past(sync_en)) |-> trig_act);
endmodule

// File: rtl/tmr_trig_clk_sel.sv
module tmr_trig_clk_sel
    import tmr_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic [MODE_W-1:0] slave_mode,
    input  logic              ext2_en,
    input  logic              sync_en,
    input  logic              itr0,
    input  logic              ti1_edge,
    input  logic              ti1_filt,
    input  logic              ti2_filt,
    input  logic              etr_cond,
    output logic              trig_in,
    output logic              cnt_en,
    output logic              trig_out,
    output logic              trig_act
);
    localparam int RISE_TRIG = 0;
    localparam int RISE_ETR  = 1;

    logic [SEL_W-1:0] sel_q;
    logic [1:0]       rise;
    logic             evt;
    clk_src_t         src;

    always_ff @(posedge clk) begin
        if (!rst_n)                              sel_q <= SEL_ITR0;
        else if (sel_wr && slave_mode == MODE_OFF) sel_q <= sel_wdata;
    end

    tsel_trig_mux u_mux (
        .sel      (sel_q),
        .itr0     (itr0),
        .ti1_edge (ti1_edge),
        .ti1_filt (ti1_filt),
        .ti2_filt (ti2_filt),
        .etr_cond (etr_cond),
        .trig     (trig_in)
    );

    tsel_rise_det #(.WIDTH(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({etr_cond, trig_in}),
        .rise  (rise)
    );

    always_comb begin
        if (ext2_en)                        src = SRC_EXT2;
        else if (slave_mode == MODE_EXT1)   src = SRC_EXT1;
        else                                src = SRC_INT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en <= 1'b0;
        end else begin
            unique case (src)
                SRC_EXT2: cnt_en <= rise[RISE_ETR];
                SRC_EXT1: cnt_en <= rise[RISE_TRIG];
                SRC_INT:  cnt_en <= 1'b1;
                default:  cnt_en <= 1'b0;
            endcase
        end
    end

    assign evt = rise[RISE_TRIG] && (slave_mode != MODE_OFF)
                 && !(ext2_en && sel_q == SEL_ETR);

    tsel_sync_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .sync_en  (sync_en),
        .trig_out (trig_out),
        .trig_act (trig_act)
    );

    // R3: selection is frozen while a slave mode is active
    assert_sel_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode != MODE_OFF) |=> $stable(sel_q));
    // R8: trigger output lasts one cycle
    assert_trgo_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);
    // R9: no trigger events with mode 2 on the external trigger select
    assert_no_trig_etr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext2_en && sel_q == SEL_ETR) |=> !trig_out);
    // R4: mode-2 count pulses are single cycles
    assert_ext2_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext2_en && cnt_en) |=> !cnt_en);
    // R7: internal clock keeps the counter enabled
    assert_int_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext2_en && slave_mode != MODE_EXT1) |=> cnt_en);
endmodule

// File: tb/tb_tmr_trig_clk_sel.sv
module tb_tmr_trig_clk_sel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = '0;
    logic [2:0] slave_mode = '0;
    logic       ext2_en = 1'b0, sync_en = 1'b0;
    logic       itr0 = 1'b0, ti1_edge = 1'b0, ti1_filt = 1'b0, ti2_filt = 1'b0, etr_cond = 1'b0;
    logic       trig_in, cnt_en, trig_out, trig_act;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_trig_clk_sel dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .slave_mode(slave_mode), .ext2_en(ext2_en), .sync_en(sync_en),
        .itr0(itr0), .ti1_edge(ti1_edge), .ti1_filt(ti1_filt), .ti2_filt(ti2_filt),
        .etr_cond(etr_cond), .trig_in(trig_in), .cnt_en(cnt_en),
        .trig_out(trig_out), .trig_act(trig_act)
    );

    // {sel[2:0], itr0, ti1_edge, ti1_filt, ti2_filt, etr, expected trig_in}
    localparam logic [8:0] VEC [14] = '{
        9'b000_10000_1, 9'b000_01111_0,
        9'b100_01000_1, 9'b100_10111_0,
        9'b101_00100_1, 9'b101_11011_0,
        9'b110_00010_1, 9'b110_11101_0,
        9'b111_00001_1, 9'b111_11110_0,
        9'b001_11111_0, 9'b010_11111_0,
        9'b011_11111_0, 9'b000_00000_0
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cand(input logic [4:0] c);
        {itr0, ti1_edge, ti1_filt, ti2_filt, etr_cond} = c;
    endtask

    task automatic write_sel(input logic [2:0] v);
        sel_wr = 1'b1;
        sel_wdata = v;
        tick();
        sel_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        // R11: reset state
        chk("R11 cnt_en", cnt_en, 1'b0);
        chk("R11 trig_out", trig_out, 1'b0);
        chk("R11 trig_act", trig_act, 1'b0);
        rst_n = 1'b1;
        tick();
        // R7: internal clock
        chk("R7 cnt_en", cnt_en, 1'b1);
        tick();
        chk("R7 cnt_en hold", cnt_en, 1'b1);

        // R1 / R2: routing table
        for (int i = 0; i < 14; i++) begin
            set_cand(5'b0);
            write_sel(VEC[i][8:6]);
            set_cand(VEC[i][5:1]);
            #1;
            chk((VEC[i][8:6] inside {3'b001, 3'b010, 3'b011}) ? "R2 trig_in" : "R1 trig_in",
                trig_in, VEC[i][0]);
            tick();
        end
        set_cand(5'b0);
        tick();

        // R4: mode 2 counts etr rising edges
        ext2_en = 1'b1;
        tick();
        chk("R4 idle", cnt_en, 1'b0);
        etr_cond = 1'b1; tick();
        chk("R4 edge", cnt_en, 1'b1);
        tick();
        chk("R4 level", cnt_en, 1'b0);
        etr_cond = 1'b0; tick();
        chk("R4 fall", cnt_en, 1'b0);
        ext2_en = 1'b0;

        // R5: mode 1 with select 111
        write_sel(3'b111);
        slave_mode = 3'b111;
        tick();
        chk("R5 idle", cnt_en, 1'b0);
        etr_cond = 1'b1; tick();
        chk("R5 edge", cnt_en, 1'b1);
        tick();
        chk("R5 level", cnt_en, 1'b0);
        etr_cond = 1'b0; tick();

        // R6: both modes on, select input-1 edge
        slave_mode = 3'b000;
        write_sel(3'b100);
        slave_mode = 3'b111;
        ext2_en = 1'b1;
        tick();
        ti1_edge = 1'b1; tick();
        chk("R6 trig edge ignored", cnt_en, 1'b0);
        etr_cond = 1'b1; tick();
        chk("R6 etr counts", cnt_en, 1'b1);
        ti1_edge = 1'b0; etr_cond = 1'b0; ext2_en = 1'b0;
        tick();

        // R3: write ignored in non-zero slave mode
        slave_mode = 3'b110;
        write_sel(3'b101);
        ti1_filt = 1'b1; #1;
        chk("R3 rejected write", trig_in, 1'b0);
        ti1_filt = 1'b0;
        ti1_edge = 1'b1; #1;
        chk("R3 old select kept", trig_in, 1'b1);
        ti1_edge = 1'b0;
        tick(); tick();

        // R8 / R10: trigger events, sync off then on
        slave_mode = 3'b000;
        write_sel(3'b101);
        slave_mode = 3'b110;
        sync_en = 1'b0;
        tick();
        ti1_filt = 1'b1; tick();
        chk("R8 trig_out", trig_out, 1'b1);
        chk("R10 act direct", trig_act, 1'b1);
        tick();
        chk("R8 one cycle", trig_out, 1'b0);
        chk("R10 act clear", trig_act, 1'b0);
        ti1_filt = 1'b0; sync_en = 1'b1; tick();
        ti1_filt = 1'b1; tick();
        chk("R8 trig_out sync", trig_out, 1'b1);
        chk("R10 act held", trig_act, 1'b0);
        tick();
        chk("R10 act delayed", trig_act, 1'b1);
        chk("R8 trig_out low", trig_out, 1'b0);
        tick();
        chk("R10 act once", trig_act, 1'b0);
        ti1_filt = 1'b0; sync_en = 1'b0;

        // R8: no event in slave mode 000
        slave_mode = 3'b000;
        tick();
        ti1_filt = 1'b1; tick();
        chk("R8 mode off", trig_out, 1'b0);
        ti1_filt = 1'b0; tick();

        // R9: mode 2 with select 111 suppresses events
        write_sel(3'b111);
        slave_mode = 3'b100;
        ext2_en = 1'b1;
        tick();
        etr_cond = 1'b1; tick();
        chk("R9 count", cnt_en, 1'b1);
        chk("R9 no trig", trig_out, 1'b0);
        etr_cond = 1'b0;
        slave_mode = 3'b000;
        write_sel(3'b101);
        slave_mode = 3'b100;
        tick();
        ti1_filt = 1'b1; etr_cond = 1'b1; tick();
        chk("R9 trig alongside", trig_out, 1'b1);
        chk("R9 count alongside", cnt_en, 1'b1);
        ti1_filt = 1'b0; etr_cond = 1'b0; ext2_en = 1'b0;
        tick();

        // R11: reset restores select 000
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        slave_mode = 3'b000;
        itr0 = 1'b1; #1;
        chk("R11 select cleared", trig_in, 1'b1);
        itr0 = 1'b0;
        tick();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule